// File: doc/BRIEF.md
# Codec Register Access Controller

This block sits between a host register file and the command side of an audio codec link. Software writes one 32-bit control word that carries a read/write selector, a 7-bit codec register index, 16 bits of write data, two power-down requests, a warm-reset request and a launch flag. While the launch flag is set, the block offers the command on a valid/ready port. The flag drops by itself once the codec side has taken the command, so software can poll the control word to see that the command has been issued.

A read command arms a response matcher with the requested index. The first response on the response port whose index matches is latched into a status word, together with its data, and a fresh-data flag is raised. Reading the status word clears that flag. Responses that do not match, and responses that arrive when no read is outstanding, leave the status word untouched. The two codec-ready inputs are synchronised and shown in the status word.

Top module: `codec_reg_access`

## Requirements
- R1: After reset the control readback and the status word read all zeros (ready inputs held low), `cmdValid` is low and both power-down outputs are low.
- R2: A control write accepted while idle is read back unchanged on `ctlRdData`: bit 31 read (1) / write (0), bits 30:24 register index, bit 21 primary power-down, bit 20 secondary power-down, bit 17 warm reset, bit 16 launch flag, bits 15:0 write data. All other bits read zero.
- R3: When an accepted write has bit 16 set, `cmdValid` is high from the next cycle on. It stays high while `cmdReady` is low, and both `cmdValid` and readback bit 16 are low in the cycle after the cycle where `cmdValid` and `cmdReady` are both high. A write with bit 16 clear only updates the fields and launches nothing.
- R4: While a command is offered, `cmdIsRead`, `cmdIndex`, `cmdData` and `cmdWarmReset` equal control bits 31, 30:24, 15:0 and 17 of the accepted word.
- R5: A control write made while the launch flag is still set is ignored completely. The readback and the offered command keep their previous values.
- R6: Once a read command has been taken, a response whose index equals the requested index is latched in the following cycle. The status word then shows the index in bits 30:24, the data in bits 15:0 and the fresh-data flag in bit 17. Bits 31, 21:18 and 16 read zero.
- R7: A response whose index differs from the outstanding read index, or that arrives while no read is outstanding (for example after a write command), leaves the status word unchanged.
- R8: Asserting `statRdEn` clears status bit 17 in the next cycle. If a matching response arrives in the same cycle, the flag is set instead.
- R9: `pdPrimary` and `pdSecondary` follow control bits 21 and 20 of the last accepted word.
- R10: The `priReady` and `secReady` inputs appear in status bits 23 and 22 after `SYNC_STAGES` clock edges (2 by default).
- R11: A command with bit 17 set is offered with `cmdWarmReset` high and never arms response capture, even when bit 31 is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Control word write strobe |
| ctlWrData | input | 32 | Control word write value |
| ctlRdData | output | 32 | Control word readback |
| statRdEn | input | 1 | Status read strobe; clears the fresh-data flag |
| statRdData | output | 32 | Status word |
| cmdValid | output | 1 | Command offered to codec side |
| cmdReady | input | 1 | Codec side takes the command |
| cmdIsRead | output | 1 | Command is a register read |
| cmdIndex | output | 7 | Codec register index |
| cmdData | output | 16 | Write data |
| cmdWarmReset | output | 1 | Command requests a link warm reset |
| rspValid | input | 1 | Response present |
| rspIndex | input | 7 | Register index tag of the response |
| rspData | input | 16 | Response read data |
| priReady | input | 1 | Primary codec ready |
| secReady | input | 1 | Secondary codec ready |
| pdPrimary | output | 1 | Primary codec power-down request |
| pdSecondary | output | 1 | Secondary codec power-down request |

## Verification
A stuck launch flag shows within one cycle of the handshake, as `cmdValid` stays high and readback bit 16 stays set. A flag that clears too early shows as `cmdValid` dropping while `cmdReady` is low. A wrong armed index or a wrong armed state shows up in the cycle after the next response: a matching read goes uncaptured, or a stray response overwrites the status word. A fresh-data flag that mis-clears is visible one cycle after a status read.

// File: rtl/codec_acc_pkg.sv
package codec_acc_pkg;
  localparam int IDX_W = 7;
  localparam int DAT_W = 16;
  localparam int WORD_W = 32;

  // control word bit positions (software visible)
  localparam int C_READ   = 31;
  localparam int C_IDX_LO = 24;
  localparam int C_PD_PRI = 21;
  localparam int C_PD_SEC = 20;
  localparam int C_WARM   = 17;
  localparam int C_LAUNCH = 16;

  // status word bit positions
  localparam int S_RDY_PRI = 23;
  localparam int S_RDY_SEC = 22;
  localparam int S_FRESH   = 17;

  typedef struct packed {
    logic loadCtl;   // accept software control write
    logic launch;    // command taken by codec side
    logic capture;   // matching response latched
  } strobe_t;
endpackage

// File: rtl/codec_acc_ctrl.sv
module codec_acc_ctrl
  import codec_acc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctlWrEn,
  input  logic    wrLaunchBit,
  input  logic    cmdReady,
  input  logic    launchArms,
  input  logic    rspValid,
  input  logic    rspMatch,
  input  logic    statRdEn,
  output strobe_t stb,
  output logic    launchPending,
  output logic    freshFlag
);
  logic awaitingQ;

  always_comb begin
    stb.loadCtl = ctlWrEn && !launchPending;
    stb.launch  = launchPending && cmdReady;
    stb.capture = rspValid && awaitingQ && rspMatch;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      launchPending <= 1'b0;
      awaitingQ     <= 1'b0;
      freshFlag     <= 1'b0;
    end else begin
      if (stb.loadCtl)     launchPending <= wrLaunchBit;
      else if (stb.launch) launchPending <= 1'b0;

      if (stb.launch && launchArms) awaitingQ <= 1'b1;
      else if (stb.capture)         awaitingQ <= 1'b0;

      if (stb.capture)   freshFlag <= 1'b1;
      else if (statRdEn) freshFlag <= 1'b0;
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (launchPending && !cmdReady) |=> launchPending); // R3
  AST_DROP_AFTER_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (launchPending && cmdReady) |=> !launchPending); // R3
  AST_FRESH_NEEDS_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freshFlag) |-> $past(rspValid && awaitingQ)); // R6
  AST_READ_CLEARS_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    (statRdEn && !rspValid) |=> !freshFlag); // R8
endmodule

// File: rtl/codec_acc_dp.sv
module codec_acc_dp
  import codec_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] ctlWrData,
  input  logic              launchPending,
  input  logic              freshFlag,
  input  logic [IDX_W-1:0]  rspIndex,
  input  logic [DAT_W-1:0]  rspData,
  input  logic              priReady,
  input  logic              secReady,
  output logic [WORD_W-1:0] ctlRdData,
  output logic [WORD_W-1:0] statRdData,
  output logic              cmdIsRead,
  output logic [IDX_W-1:0]  cmdIndex,
  output logic [DAT_W-1:0]  cmdData,
  output logic              cmdWarmReset,
  output logic              pdPrimary,
  output logic              pdSecondary,
  output logic              launchArms,
  output logic              rspMatch
);
  localparam int LAST = SYNC_STAGES - 1;

  logic             isReadQ, warmQ, pdPriQ, pdSecQ;
  logic [IDX_W-1:0] idxQ, awaitIdxQ, stIdxQ;
  logic [DAT_W-1:0] wDataQ, stDataQ;
  logic [1:0]       syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isReadQ   <= 1'b0;
      warmQ     <= 1'b0;
      pdPriQ    <= 1'b0;
      pdSecQ    <= 1'b0;
      idxQ      <= '0;
      wDataQ    <= '0;
      awaitIdxQ <= '0;
      stIdxQ    <= '0;
      stDataQ   <= '0;
    end else begin
      if (stb.loadCtl) begin
        isReadQ <= ctlWrData[C_READ];
        idxQ    <= ctlWrData[C_IDX_LO +: IDX_W];
        pdPriQ  <= ctlWrData[C_PD_PRI];
        pdSecQ  <= ctlWrData[C_PD_SEC];
        warmQ   <= ctlWrData[C_WARM];
        wDataQ  <= ctlWrData[DAT_W-1:0];
      end
      if (stb.launch && launchArms) awaitIdxQ <= idxQ;
      if (stb.capture) begin
        stIdxQ  <= rspIndex;
        stDataQ <= rspData;
      end
    end
  end

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gs] <= 2'b00;
        else if (gs == 0) syncQ[gs] <= {priReady, secReady};
        else syncQ[gs] <= syncQ[(gs == 0) ? 0 : gs - 1];
      end
    end
  endgenerate

  always_comb begin
    launchArms = isReadQ && !warmQ;
    rspMatch   = (rspIndex == awaitIdxQ);

    cmdIsRead    = isReadQ;
    cmdIndex     = idxQ;
    cmdData      = wDataQ;
    cmdWarmReset = warmQ;
    pdPrimary    = pdPriQ;
    pdSecondary  = pdSecQ;

    ctlRdData                        = '0;
    ctlRdData[C_READ]                = isReadQ;
    ctlRdData[C_IDX_LO +: IDX_W]     = idxQ;
    ctlRdData[C_PD_PRI]              = pdPriQ;
    ctlRdData[C_PD_SEC]              = pdSecQ;
    ctlRdData[C_WARM]                = warmQ;
    ctlRdData[C_LAUNCH]              = launchPending;
    ctlRdData[DAT_W-1:0]             = wDataQ;

    statRdData                       = '0;
    statRdData[C_IDX_LO +: IDX_W]    = stIdxQ;
    statRdData[S_RDY_PRI]            = syncQ[LAST][1];
    statRdData[S_RDY_SEC]            = syncQ[LAST][0];
    statRdData[S_FRESH]              = freshFlag;
    statRdData[DAT_W-1:0]            = stDataQ;
  end

  AST_CAPTURE_TAKES_RESPONSE: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (stIdxQ == $past(rspIndex)) && (stDataQ == $past(rspData))); // R6
endmodule

// File: rtl/codec_reg_access.sv
module codec_reg_access
  import codec_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWrEn,
  input  logic [31:0] ctlWrData,
  output logic [31:0] ctlRdData,
  input  logic        statRdEn,
  output logic [31:0] statRdData,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic        cmdIsRead,
  output logic [6:0]  cmdIndex,
  output logic [15:0] cmdData,
  output logic        cmdWarmReset,
  input  logic        rspValid,
  input  logic [6:0]  rspIndex,
  input  logic [15:0] rspData,
  input  logic        priReady,
  input  logic        secReady,
  output logic        pdPrimary,
  output logic        pdSecondary
);
  strobe_t stb;
  logic    launchPending, freshFlag, launchArms, rspMatch;

  codec_acc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .wrLaunchBit(ctlWrData[C_LAUNCH]),
    .cmdReady(cmdReady), .launchArms(launchArms), .rspValid(rspValid),
    .rspMatch(rspMatch), .statRdEn(statRdEn), .stb(stb),
    .launchPending(launchPending), .freshFlag(freshFlag)
  );

  codec_acc_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctlWrData(ctlWrData),
    .launchPending(launchPending), .freshFlag(freshFlag),
    .rspIndex(rspIndex), .rspData(rspData), .priReady(priReady), .secReady(secReady),
    .ctlRdData(ctlRdData), .statRdData(statRdData), .cmdIsRead(cmdIsRead),
    .cmdIndex(cmdIndex), .cmdData(cmdData), .cmdWarmReset(cmdWarmReset),
    .pdPrimary(pdPrimary), .pdSecondary(pdSecondary),
    .launchArms(launchArms), .rspMatch(rspMatch)
  );

  assign cmdValid = launchPending;

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWrEn && cmdValid) |=> $stable(ctlRdData[31:17]) && $stable(ctlRdData[15:0])); // R5
  AST_STATUS_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |=> $stable(statRdData[30:24]) && $stable(statRdData[15:0])); // R7
endmodule

// File: tb/sim_codec_reg_access.sv
`timescale 1ns/1ps
module sim_codec_reg_access;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWrEn = 1'b0;
  logic [31:0] ctlWrData = '0;
  logic [31:0] ctlRdData;
  logic        statRdEn = 1'b0;
  logic [31:0] statRdData;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic        cmdIsRead;
  logic [6:0]  cmdIndex;
  logic [15:0] cmdData;
  logic        cmdWarmReset;
  logic        rspValid = 1'b0;
  logic [6:0]  rspIndex = '0;
  logic [15:0] rspData = '0;
  logic        priReady = 1'b0;
  logic        secReady = 1'b0;
  logic        pdPrimary, pdSecondary;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [6:0]  expIdx = '0;
  logic [15:0] expData = '0;

  always #2.5 clk = ~clk;

  codec_reg_access u0 (.*);

  // word, response index, response data
  localparam logic [54:0] VECS [0:5] = '{
    {32'hA6010000, 7'h26, 16'h1234},
    {32'h02018080, 7'h02, 16'h4444},
    {32'hFC010000, 7'h7C, 16'h5A5A},
    {32'h98010000, 7'h19, 16'h9999},
    {32'h0001FFFF, 7'h00, 16'h0F0F},
    {32'hFF01BEEF, 7'h7F, 16'hCAFE}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stWord(logic [6:0] idx, logic [15:0] d, logic fresh);
    return {1'b0, idx, priReady, secReady, 4'b0, fresh, 1'b0, d};
  endfunction

  task automatic writeCtl(logic [31:0] w);
    ctlWrEn = 1'b1; ctlWrData = w;
    tick();
    ctlWrEn = 1'b0;
  endtask

  task automatic takeCmd();
    cmdReady = 1'b1;
    tick();
    cmdReady = 1'b0;
  endtask

  task automatic respond(logic [6:0] i, logic [15:0] d, logic rd);
    rspValid = 1'b1; rspIndex = i; rspData = d; statRdEn = rd;
    tick();
    rspValid = 1'b0; statRdEn = 1'b0;
  endtask

  task automatic readStatus();
    statRdEn = 1'b1;
    tick();
    statRdEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 ctl", ctlRdData, 32'h0);
    check("R1 stat", statRdData, 32'h0);
    check("R1 valid", {31'b0, cmdValid}, 32'h0);
    check("R1 pd", {30'b0, pdPrimary, pdSecondary}, 32'h0);

    // R10 ready synchronisation
    priReady = 1'b1; secReady = 1'b0;
    tick();
    check("R10 early", {30'b0, statRdData[23:22]}, 32'h0);
    tick();
    check("R10 settled", {30'b0, statRdData[23:22]}, 32'h2);

    // R2 / R9 field write without launch
    writeCtl(32'h85301234);
    check("R2 readback", ctlRdData, 32'h85301234);
    check("R9 pd both", {30'b0, pdPrimary, pdSecondary}, 32'h3);
    check("R3 no launch", {31'b0, cmdValid}, 32'h0);
    tick();
    check("R3 no launch later", {31'b0, cmdValid}, 32'h0);
    writeCtl(32'h00200000);
    check("R9 pd primary only", {30'b0, pdPrimary, pdSecondary}, 32'h2);
    writeCtl(32'h0);

    // R5 write while busy is ignored
    writeCtl(32'h81010001);
    check("R3 launch", {31'b0, cmdValid}, 32'h1);
    writeCtl(32'h02027777);
    check("R5 readback kept", ctlRdData, 32'h81010001);
    check("R5 index kept", {25'b0, cmdIndex}, 32'h1);
    takeCmd();
    check("R3 cleared", ctlRdData, 32'h81000001);
    respond(7'h01, 16'h0101, 1'b0);
    check("R6 captured", statRdData, stWord(7'h01, 16'h0101, 1'b1));
    readStatus();
    check("R8 cleared", statRdData, stWord(7'h01, 16'h0101, 1'b0));

    // R8 capture and status read in the same cycle
    writeCtl(32'h83010000);
    takeCmd();
    respond(7'h03, 16'h3333, 1'b1);
    check("R8 capture wins", statRdData, stWord(7'h03, 16'h3333, 1'b1));
    readStatus();
    check("R8 clear after", statRdData, stWord(7'h03, 16'h3333, 1'b0));
    expIdx = 7'h03; expData = 16'h3333;

    // vector table
    for (int i = 0; i < 6; i++) begin
      logic [31:0] w;
      logic [6:0]  ri;
      logic [15:0] rd;
      logic        hit;
      w  = VECS[i][54:23];
      ri = VECS[i][22:16];
      rd = VECS[i][15:0];
      writeCtl(w);
      check("R3 valid", {31'b0, cmdValid}, 32'h1);
      check("R4 fields", {cmdIsRead, cmdIndex, 7'b0, cmdWarmReset, cmdData},
            {w[31], w[30:24], 7'b0, w[17], w[15:0]});
      tick();
      check("R3 held", {31'b0, cmdValid}, 32'h1);
      takeCmd();
      check("R3 dropped", {31'b0, cmdValid, ctlRdData[16]}, 32'h0);
      respond(ri, rd, 1'b0);
      hit = w[31] && (ri == w[30:24]);
      if (hit) begin
        expIdx = ri; expData = rd;
        check("R6 vector capture", statRdData, stWord(expIdx, expData, 1'b1));
        readStatus();
        check("R8 vector clear", statRdData, stWord(expIdx, expData, 1'b0));
      end else begin
        check("R7 ignored", statRdData, stWord(expIdx, expData, 1'b0));
      end
    end

    // R11 warm reset does not arm capture
    writeCtl(32'h80030000);
    check("R11 warm flag", {30'b0, cmdWarmReset, cmdValid}, 32'h3);
    takeCmd();
    respond(7'h00, 16'hDEAD, 1'b0);
    check("R11 no capture", statRdData, stWord(expIdx, expData, 1'b0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule